// File: doc/BRIEF.md
# Vector Bitwise Select Unit

This block executes one family of vector logic instructions: exclusive-or, bitwise select, insert-if-true and insert-if-false. A 32-bit instruction word arrives with a valid strobe. The block checks the word's fixed opcode bits and pulls out the width bit, the operation field and three register numbers. It then reads the two sources and the old destination from a built-in register file of 32 entries of 128 bits, and writes the result back to the destination.

All four operations go through one shared datapath of the form `A ^ ((B ^ Vn) & C)`. A multiplexer picks A, B and C from the old destination, Vm, all zeros and all ones, based on the operation field. Results are computed per byte lane. A narrow (64-bit) operation writes only the lower eight lanes and clears the upper eight.

Every accepted instruction takes the same single cycle, whatever the operand values. When vector execution is disabled, a matching word raises a trap flag and nothing is written. A word that fails the opcode match raises an unrecognized flag. A debug port reads any register and can preload one while no instruction is presented.

Top module: `vbit_unit`

## Requirements
- R1: A word matches only when bit 31 is 0, bit 29 is 1, bits 28:24 are 01110, bit 21 is 1, bits 15:11 are 00011 and bit 10 is 1. A valid non-matching word raises undef_o in the next cycle and writes no register.
- R2: Operation field (bits 23:22) value 00 writes Vm XOR Vn to Vd. Vn is bits 9:5, Vm is bits 20:16 and Vd is bits 4:0.
- R3: Operation field 01 (select): each result bit is the Vn bit where the old Vd bit is 1, and the Vm bit where it is 0.
- R4: Operation field 10 (insert-if-true): each result bit is the Vn bit where the Vm bit is 1, and the old Vd bit otherwise.
- R5: Operation field 11 (insert-if-false): each result bit is the Vn bit where the Vm bit is 0, and the old Vd bit otherwise.
- R6: Width bit 30 equal to 0 gives a 64-bit operation. It writes result bits 63:0 and clears bits 127:64 of Vd. Width bit 1 writes all 128 bits.
- R7: A valid matching word while fp_enable_i is low raises trap_o in the next cycle, keeps done_o low and writes no register.
- R8: A valid matching word while enabled raises done_o in the next cycle, and its result is readable on the debug port from that cycle, for any operand data.
- R9: After reset every register reads zero and done_o, trap_o and undef_o are low.
- R10: A debug write (dbg_we_i high) stores dbg_wdata_i into register dbg_addr_i at the clock edge only when instr_valid_i is low. Otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid_i | input | 1 | Instruction word is present this cycle |
| instr_i | input | 32 | Instruction word |
| fp_enable_i | input | 1 | Vector execution enabled |
| dbg_addr_i | input | 5 | Debug register number for read and write |
| dbg_we_i | input | 1 | Debug write strobe |
| dbg_wdata_i | input | 128 | Debug write data |
| dbg_rdata_o | output | 128 | Combinational read of register dbg_addr_i |
| done_o | output | 1 | Previous cycle's instruction wrote its result |
| trap_o | output | 1 | Previous cycle's instruction was trapped |
| undef_o | output | 1 | Previous cycle's word failed the opcode match |

## Verification
The bench sweeps every operation at both widths over several data patterns, including all-zeros and all-ones. It compares each result with a per-bit select model, which would catch swapped operand choices such as an inverted C in the insert-if-false case. It also runs cases where the destination is the same register as Vn or Vm. A design that wrote a partly updated destination, or read the destination after the write, would give the wrong bits there. Each of the fourteen fixed opcode bits is flipped one at a time. A loose decoder would then execute and corrupt the destination instead of flagging it. Narrow operations start from a destination that is all ones, so upper lanes left uncleared show up at once.

// File: rtl/vbit_pkg.sv
// Package: shared constants and types for the vector bitwise select unit.
// Assumes a fixed 32-bit instruction word and byte lanes.
package vbit_pkg;
    localparam int INSTR_W = 32;
    localparam int LANE_W  = 8;

    // Fixed opcode bits: which bits are checked and the value they must hold
    localparam logic [INSTR_W-1:0] FIX_MASK  = 32'hBF20_FC00;
    localparam logic [INSTR_W-1:0] FIX_VALUE = 32'h2E20_1C00;

    typedef enum logic [1:0] {
        OP_XOR   = 2'b00,
        OP_SEL   = 2'b01,
        OP_INS_T = 2'b10,
        OP_INS_F = 2'b11
    } vop_e;
endpackage

// File: rtl/vbit_decode.sv
// Module: vbit_decode
// Checks the fixed opcode bits of an instruction word and extracts the
// width bit, operation field and register numbers. Purely combinational.
// Assumes register numbers are 5 bits wide, as the field layout fixes.
module vbit_decode
    import vbit_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [INSTR_W-1:0] instr,
    output logic               hit,
    output logic               wide,
    output vop_e               op,
    output logic [AW-1:0]      rd,
    output logic [AW-1:0]      rn,
    output logic [AW-1:0]      rm
);
    // Field match and extraction
    always_comb begin
        hit  = (instr & FIX_MASK) == FIX_VALUE;
        wide = instr[30];
        op   = vop_e'(instr[23:22]);
        rm   = instr[16 +: AW];
        rn   = instr[5 +: AW];
        rd   = instr[0 +: AW];
    end
endmodule

// File: rtl/vbit_regfile.sv
// Module: vbit_regfile
// Register file with NRD combinational read ports and one synchronous
// write port. A synchronous active-low reset clears every entry.
// Assumes NREG is a power of two.
module vbit_regfile #(
    parameter int NREG = 32,
    parameter int W    = 128,
    parameter int NRD  = 4,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NRD-1:0][AW-1:0] raddr,
    output logic [NRD-1:0][W-1:0]  rdata,
    input  logic                   we,
    input  logic [AW-1:0]          waddr,
    input  logic [W-1:0]           wdata
);
    logic [W-1:0] mem [NREG];

    // Storage update: clear on reset, else single write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NRD; g++) begin : g_rd
            assign rdata[g] = mem[raddr[g]];
        end
    endgenerate
endmodule

// File: rtl/vbit_datapath.sv
// Module: vbit_datapath
// Picks the three operand inputs for the shared A ^ ((B ^ Vn) & C) expression
// by operation and evaluates it per byte lane. In narrow mode only the
// lower half of the lanes is kept and the rest are forced to zero.
// Assumes W is an even multiple of the lane width.
module vbit_datapath
    import vbit_pkg::*;
#(
    parameter int W = 128,
    localparam int LANES = W / LANE_W
) (
    input  vop_e         op,
    input  logic         wide,
    input  logic [W-1:0] vd,
    input  logic [W-1:0] vn,
    input  logic [W-1:0] vm,
    output logic [W-1:0] res
);
    logic [W-1:0] opa, opb, opc;

    // Operand selection per operation
    always_comb begin
        unique case (op)
            OP_XOR:   begin opa = vm; opb = '0; opc = '1;  end
            OP_SEL:   begin opa = vm; opb = vm; opc = vd;  end
            OP_INS_T: begin opa = vd; opb = vd; opc = vm;  end
            default:  begin opa = vd; opb = vd; opc = ~vm; end
        endcase
    end

    genvar l;
    generate
        for (l = 0; l < LANES; l++) begin : g_lane
            localparam bit UPPER = (l >= LANES / 2);
            logic lane_on;
            assign lane_on = wide || !UPPER;
            assign res[l*LANE_W +: LANE_W] = lane_on ?
                (opa[l*LANE_W +: LANE_W] ^
                 ((opb[l*LANE_W +: LANE_W] ^ vn[l*LANE_W +: LANE_W]) &
                  opc[l*LANE_W +: LANE_W])) : '0;
        end
    endgenerate
endmodule

// File: rtl/vbit_unit.sv
// Module: vbit_unit (top)
// Decodes one instruction per cycle. It reads Vd, Vn and Vm in the same
// cycle and writes the result at the closing clock edge, so every
// accepted instruction takes exactly one cycle. The status flags are
// registered and describe the previous cycle's word. A debug port
// reads any register, and writes one only while no instruction is
// presented. Assumes a single clock domain with a synchronous
// active-low reset.
module vbit_unit
    import vbit_pkg::*;
#(
    parameter int NREG = 32,
    parameter int W    = 128,
    localparam int AW  = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic               fp_enable_i,
    input  logic [AW-1:0]      dbg_addr_i,
    input  logic               dbg_we_i,
    input  logic [W-1:0]       dbg_wdata_i,
    output logic [W-1:0]       dbg_rdata_o,
    output logic               done_o,
    output logic               trap_o,
    output logic               undef_o
);
    localparam int NRD = 4;

    logic          hit, wide;
    vop_e          op;
    logic [AW-1:0] rd, rn, rm;
    logic [NRD-1:0][AW-1:0] raddr;
    logic [NRD-1:0][W-1:0]  rdata;
    logic [W-1:0]  res;
    logic          exec_ok, rf_we;
    logic [AW-1:0] rf_waddr;
    logic [W-1:0]  rf_wdata;

    vbit_decode #(.AW(AW)) u_dec (
        .instr(instr_i), .hit(hit), .wide(wide), .op(op),
        .rd(rd), .rn(rn), .rm(rm)
    );

    // Read port assignment: old Vd, Vn, Vm, debug
    always_comb begin
        raddr[0] = rd;
        raddr[1] = rn;
        raddr[2] = rm;
        raddr[3] = dbg_addr_i;
    end

    vbit_regfile #(.NREG(NREG), .W(W), .NRD(NRD)) u_rf (
        .clk(clk), .rst_n(rst_n), .raddr(raddr), .rdata(rdata),
        .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata)
    );

    vbit_datapath #(.W(W)) u_dp (
        .op(op), .wide(wide), .vd(rdata[0]), .vn(rdata[1]), .vm(rdata[2]),
        .res(res)
    );

    // Write source choice: instruction result first, debug data when idle
    always_comb begin
        exec_ok  = instr_valid_i && hit && fp_enable_i;
        rf_we    = exec_ok || (dbg_we_i && !instr_valid_i);
        rf_waddr = exec_ok ? rd : dbg_addr_i;
        rf_wdata = exec_ok ? res : dbg_wdata_i;
    end

    assign dbg_rdata_o = rdata[3];

    // Status flags for the word seen in the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o  <= 1'b0;
            trap_o  <= 1'b0;
            undef_o <= 1'b0;
        end else begin
            done_o  <= exec_ok;
            trap_o  <= instr_valid_i && hit && !fp_enable_i;
            undef_o <= instr_valid_i && !hit;
        end
    end
endmodule

// File: rtl/vbit_unit_chk.sv
// Module: vbit_unit_chk
// Protocol checker bound to vbit_unit. It relates the instruction inputs
// to the registered status flags one cycle later.
module vbit_unit_chk
    import vbit_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               instr_valid_i,
    input logic [INSTR_W-1:0] instr_i,
    input logic               fp_enable_i,
    input logic               done_o,
    input logic               trap_o,
    input logic               undef_o
);
    // R1
    undef_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid_i && ((instr_i & 32'hBF20_FC00) != 32'h2E20_1C00))
        |=> (undef_o && !done_o));

    // R7
    trap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid_i && ((instr_i & 32'hBF20_FC00) == 32'h2E20_1C00) && !fp_enable_i)
        |=> (trap_o && !done_o));

    // R8
    fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid_i && ((instr_i & 32'hBF20_FC00) == 32'h2E20_1C00) && fp_enable_i)
        |=> done_o);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid_i |=> !(done_o || trap_o || undef_o));

    // R1
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, trap_o, undef_o}));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !(done_o || trap_o || undef_o));
endmodule

bind vbit_unit vbit_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .instr_valid_i(instr_valid_i),
    .instr_i(instr_i), .fp_enable_i(fp_enable_i),
    .done_o(done_o), .trap_o(trap_o), .undef_o(undef_o)
);

// File: tb/tb_vbit_unit.sv
`timescale 1ns/1ps
module tb_vbit_unit;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         instr_valid_i;
    logic [31:0]  instr_i;
    logic         fp_enable_i;
    logic [4:0]   dbg_addr_i;
    logic         dbg_we_i;
    logic [127:0] dbg_wdata_i;
    logic [127:0] dbg_rdata_o;
    logic         done_o, trap_o, undef_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    vbit_unit dut (
        .clk(clk), .rst_n(rst_n), .instr_valid_i(instr_valid_i),
        .instr_i(instr_i), .fp_enable_i(fp_enable_i),
        .dbg_addr_i(dbg_addr_i), .dbg_we_i(dbg_we_i),
        .dbg_wdata_i(dbg_wdata_i), .dbg_rdata_o(dbg_rdata_o),
        .done_o(done_o), .trap_o(trap_o), .undef_o(undef_o)
    );

    task automatic check(input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input logic q, input logic [1:0] op,
        input logic [4:0] rd, input logic [4:0] rn, input logic [4:0] rm);
        return {1'b0, q, 1'b1, 5'b01110, op, 1'b1, rm, 5'b00011, 1'b1, rn, rd};
    endfunction

    function automatic logic [127:0] pat(input int k);
        logic [127:0] v;
        if (k == 0) return '0;
        if (k == 1) return '1;
        for (int w = 0; w < 4; w++)
            v[w*32 +: 32] = 32'((k * 4 + w + 1) * 32'h9E3779B1) ^ (32'(k) << (w * 5));
        return v;
    endfunction

    // Per-bit select model from the requirements (R2..R6)
    function automatic logic [127:0] model(input logic [1:0] op, input logic q,
        input logic [127:0] vd, input logic [127:0] vn, input logic [127:0] vm);
        logic [127:0] r;
        for (int i = 0; i < 128; i++) begin
            if (!q && i >= 64) r[i] = 1'b0;
            else case (op)
                2'b00: r[i] = vm[i] ^ vn[i];
                2'b01: r[i] = vd[i] ? vn[i] : vm[i];
                2'b10: r[i] = vm[i] ? vn[i] : vd[i];
                default: r[i] = vm[i] ? vd[i] : vn[i];
            endcase
        end
        return r;
    endfunction

    task automatic load(input logic [4:0] r, input logic [127:0] v);
        @(negedge clk);
        dbg_we_i = 1'b1; dbg_addr_i = r; dbg_wdata_i = v;
        @(negedge clk);
        dbg_we_i = 1'b0;
    endtask

    task automatic readreg(input logic [4:0] r, output logic [127:0] v);
        dbg_addr_i = r;
        #1;
        v = dbg_rdata_o;
    endtask

    // Present one word for one cycle; flags are sampled in the next cycle
    task automatic issue(input logic [31:0] w, input logic en,
                         output logic [2:0] flags);
        @(negedge clk);
        instr_i = w; instr_valid_i = 1'b1; fp_enable_i = en;
        @(negedge clk);
        instr_valid_i = 1'b0; fp_enable_i = 1'b1;
        flags = {done_o, trap_o, undef_o};
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++; checks++;
                $display("FAIL watchdog actual=%0d expected<=100000", cyc);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [127:0] v, vd, vn, vm, exp;
        logic [2:0] fl;
        logic [31:0] good;
        rst_n = 1'b0; instr_valid_i = 1'b0; instr_i = '0; fp_enable_i = 1'b1;
        dbg_addr_i = '0; dbg_we_i = 1'b0; dbg_wdata_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state
        check("R9 flags", {125'd0, done_o, trap_o, undef_o}, '0);
        for (int r = 0; r < 32; r += 7) begin
            readreg(5'(r), v);
            check("R9 reg", v, '0);
        end

        // R2..R6, R8: sweep op x width x patterns, with aliasing cases
        for (int op = 0; op < 4; op++) begin
            for (int q = 0; q < 2; q++) begin
                for (int k = 0; k < 7; k++) begin
                    logic [4:0] rd, rn, rm;
                    rd = 5'((k * 3 + op + 1) % 32);
                    rn = 5'((k * 5 + 11) % 32);
                    rm = 5'((k * 7 + 20) % 32);
                    if (rn == rd) rn = rn + 5'd1;
                    if (rm == rd || rm == rn) rm = rm + 5'd2;
                    if (k == 5) rn = rd;
                    if (k == 6) rm = rd;
                    vd = (k == 2) ? '1 : pat(k + 10 * op + 3);
                    vn = pat(k);
                    vm = pat((k + 1) % 7 + 20 * q);
                    load(rn, vn);
                    load(rm, vm);
                    load(rd, vd);
                    readreg(rd, vd); readreg(rn, vn); readreg(rm, vm);
                    exp = model(2'(op), q[0], vd, vn, vm);
                    issue(enc(q[0], 2'(op), rd, rn, rm), 1'b1, fl);
                    check("R8 done flag", {125'd0, fl}, 128'd4);
                    readreg(rd, v);
                    case (op)
                        0: check(q ? "R2 xor wide" : "R2 xor narrow R6", v, exp);
                        1: check(q ? "R3 select wide" : "R3 select narrow R6", v, exp);
                        2: check(q ? "R4 ins-true wide" : "R4 ins-true narrow R6", v, exp);
                        default: check(q ? "R5 ins-false wide" : "R5 ins-false narrow R6", v, exp);
                    endcase
                end
            end
        end

        // R6: narrow op clears the upper half of an all-ones destination
        load(5'd3, '1); load(5'd4, '1); load(5'd5, '0);
        issue(enc(1'b0, 2'b00, 5'd3, 5'd4, 5'd5), 1'b1, fl);
        readreg(5'd3, v);
        check("R6 upper cleared", v, {64'd0, {64{1'b1}}});

        // R7: trap when disabled, destination kept
        load(5'd8, pat(40)); load(5'd9, pat(41)); load(5'd10, pat(42));
        issue(enc(1'b1, 2'b01, 5'd8, 5'd9, 5'd10), 1'b0, fl);
        check("R7 trap flag", {125'd0, fl}, 128'd2);
        readreg(5'd8, v);
        check("R7 no write", v, pat(40));

        // R1: flip each fixed opcode bit; flagged and destination kept
        good = enc(1'b1, 2'b00, 5'd12, 5'd13, 5'd14);
        load(5'd12, pat(50)); load(5'd13, pat(51)); load(5'd14, pat(52));
        for (int b = 0; b < 32; b++) begin
            if (b == 31 || b == 29 || (b >= 24 && b <= 28) || b == 21 ||
                (b >= 10 && b <= 15)) begin
                issue(good ^ (32'd1 << b), 1'b1, fl);
                check("R1 undef flag", {125'd0, fl}, 128'd1);
                readreg(5'd12, v);
                check("R1 no write", v, pat(50));
            end
        end

        // R10: debug write ignored while an instruction is presented
        load(5'd20, pat(60));
        load(5'd21, pat(61)); load(5'd22, pat(62)); load(5'd23, pat(63));
        @(negedge clk);
        instr_i = enc(1'b1, 2'b00, 5'd21, 5'd22, 5'd23); instr_valid_i = 1'b1;
        dbg_we_i = 1'b1; dbg_addr_i = 5'd20; dbg_wdata_i = pat(99);
        @(negedge clk);
        instr_valid_i = 1'b0; dbg_we_i = 1'b0;
        readreg(5'd20, v);
        check("R10 debug write ignored", v, pat(60));
        readreg(5'd21, v);
        check("R10 instruction still ran R2", v, pat(62) ^ pat(63));
        load(5'd20, pat(70));
        readreg(5'd20, v);
        check("R10 debug write when idle", v, pat(70));

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule